// File: doc/BRIEF.md
# Windowed Watchdog Timeout Counter

This block is a watchdog counter that a chip-level reset controller uses to recover from stuck software. It counts ticks from one of four sources: the bus clock itself, or one of three slower sources. The slower sources arrive as one-bus-clock enable pulses that have already been brought into the bus clock domain. A fixed divide-by-256 prescaler can be switched in to stretch the timeout. The 16-bit count is compared with a programmable timeout. When the count reaches it, the block requests a reset. In interrupt mode it first raises an early-warning interrupt and requests the reset a fixed 128 bus clocks later.

Software restarts the count with a two-word key written to the count port. A wrong second word, or a second word that arrives too late, is treated as a fault and requests a reset at once. In windowed mode a correct key that lands while the count is still at or below the window value is also a fault. This catches program flow that runs faster than expected. When the block is disabled, the count is held at zero and every output stays low.

Top module: `wdt_window_ctr`

## Requirements
- R1: With the interrupt disabled, `rst_req` rises one bus clock after `count` first becomes greater than or equal to `cfg_timeout`, and not before.
- R2: `cfg_src_sel` picks the count source: 0 counts every bus clock, 1 counts `tick_lpo` pulses, 2 counts `tick_irc` pulses, 3 counts `tick_ext` pulses. Pulses on the unselected tick inputs do not change `count`.
- R3: With `cfg_prescale` high, `count` advances once for every 256 selected ticks.
- R4: A write of 0x02A6 followed by a write of 0x80B4 clears `count` to zero on the clock that takes the second write. The second write may land on any of the 16 bus clocks after the first. A write of any other value while no key is pending has no effect.
- R5: After a 0x02A6 write, a following write of any value other than 0x80B4 requests a reset on that clock. So does the absence of any write for 16 bus clocks.
- R6: With `cfg_windowed` high, a complete key whose second word lands while `count` is at or below `cfg_window` requests a reset instead of clearing the count. A key that lands while `count` is above `cfg_window` clears it normally.
- R7: With `cfg_int_en` high, the timeout sets `irq_flag` and `irq` one bus clock after `count` reaches `cfg_timeout`, and `rst_req` rises exactly 128 bus clocks after the flag.
- R8: A high `flag_clr` clears `irq_flag` and `irq` on the next clock. It does not cancel a reset that is already pending.
- R9: While `cfg_en` is low, `count` is zero and `irq`, `irq_flag` and `rst_req` are low.
- R10: Once raised, `rst_req` stays high until `cfg_en` goes low or `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Watchdog enable; low holds the block idle |
| cfg_src_sel | input | 2 | Count source select (0 bus, 1 low-power, 2 internal ref, 3 external) |
| cfg_prescale | input | 1 | Enables the fixed divide-by-256 prescaler |
| cfg_windowed | input | 1 | Enables the lower refresh window check |
| cfg_int_en | input | 1 | Enables the early-warning interrupt before reset |
| cfg_timeout | input | 16 | Timeout value |
| cfg_window | input | 16 | Lower refresh window value |
| tick_lpo | input | 1 | Synchronised tick from the 1 kHz low-power oscillator |
| tick_irc | input | 1 | Synchronised tick from the 32 kHz internal reference |
| tick_ext | input | 1 | Synchronised tick from the external reference |
| cnt_wr_valid | input | 1 | Write strobe for the count port key |
| cnt_wr_data | input | 16 | Key word written to the count port |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| irq | output | 1 | Early-warning interrupt |
| irq_flag | output | 1 | Interrupt flag |
| rst_req | output | 1 | Reset request |
| count | output | 16 | Current count value |

## Verification
Most internal faults show up on `count` or `rst_req` within one bus clock. A miscounting prescaler or source mux shows up as a wrong `count`. A key decoder stuck in the wrong state either leaves `count` uncleared on the clock after the second word, or raises `rst_req` when it should not. Errors in the gap timer and in the reset delay counter show up only at the edges of their windows. The bench therefore samples `rst_req` one clock before and one clock after the 16-clock key limit and the 128-clock delay. It also places refreshes exactly at and just above the window value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Key words of the refresh sequence (order matters)
    localparam logic [15:0] KEY_FIRST  = 16'h02A6;
    localparam logic [15:0] KEY_SECOND = 16'h80B4;

    // Count source encoding decoded by the tick generator
    typedef enum logic [1:0] {
        SRC_BUS = 2'd0,
        SRC_LPO = 2'd1,
        SRC_IRC = 2'd2,
        SRC_EXT = 2'd3
    } wdt_src_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_st_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int PRE_DIV = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] src_sel,
    input  logic       prescale,
    input  logic       tick_lpo,
    input  logic       tick_irc,
    input  logic       tick_ext,
    output logic       tick
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } tick_state_t;

    tick_state_t q, d;
    logic [3:0]  src_vec;
    logic        src_tick;
    logic        div_wrap;

    assign src_vec  = {tick_ext, tick_irc, tick_lpo, 1'b1};
    assign src_tick = src_vec[src_sel];

    generate
        if (PRE_DIV > 1) begin : g_div
            assign div_wrap = (q.div == DIV_W'(PRE_DIV - 1));
        end else begin : g_nodiv
            assign div_wrap = 1'b1;
        end
    endgenerate

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (clear) begin
            d.div = '0;
        end else if (src_tick) begin
            if (!prescale) begin
                tick = 1'b1;
            end else if (div_wrap) begin
                d.div = '0;
                tick  = 1'b1;
            end else begin
                d.div = q.div + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int KEY_GAP = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              refresh,
    output logic              seq_err
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AGE_W = (KEY_GAP > 1) ? $clog2(KEY_GAP) : 1;

    typedef struct packed {
        key_st_e          st;
        logic [AGE_W-1:0] age;
    } key_state_t;

    key_state_t q, d;

    always_comb begin
        d       = q;
        refresh = 1'b0;
        seq_err = 1'b0;
        if (clear) begin
            d.st  = KEY_IDLE;
            d.age = '0;
        end else begin
            unique case (q.st)
                KEY_IDLE: begin
                    if (wr_valid && wr_data == DATA_W'(KEY_FIRST)) begin
                        d.st  = KEY_ARMED;
                        d.age = '0;
                    end
                end
                KEY_ARMED: begin
                    if (wr_valid) begin
                        d.st = KEY_IDLE;
                        if (wr_data == DATA_W'(KEY_SECOND)) refresh = 1'b1;
                        else                                seq_err = 1'b1;
                    end else if (q.age == AGE_W'(KEY_GAP - 1)) begin
                        d.st    = KEY_IDLE;
                        seq_err = 1'b1;
                    end else begin
                        d.age = q.age + AGE_W'(1);
                    end
                end
                default: d.st = KEY_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: KEY_IDLE, age: '0};
        else        q <= d;
    end
endmodule

// File: rtl/wdt_alarm.sv
module wdt_alarm #(
    parameter int RST_DELAY = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic fire,
    input  logic fault,
    input  logic int_en,
    input  logic flag_clr,
    output logic irq,
    output logic irq_flag,
    output logic rst_req
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DLY_W = (RST_DELAY > 1) ? $clog2(RST_DELAY) : 1;

    typedef struct packed {
        logic             flag;
        logic             pend;
        logic [DLY_W-1:0] dly;
        logic             rst;
    } alarm_state_t;

    alarm_state_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else begin
            if (flag_clr) d.flag = 1'b0;
            if (q.pend) begin
                if (q.dly == DLY_W'(RST_DELAY - 1)) begin
                    d.rst  = 1'b1;
                    d.pend = 1'b0;
                end else begin
                    d.dly = q.dly + DLY_W'(1);
                end
            end
            if (fire) begin
                if (int_en) begin
                    d.flag = 1'b1;
                    d.pend = 1'b1;
                    d.dly  = '0;
                end else begin
                    d.rst = 1'b1;
                end
            end
            if (fault) d.rst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_flag = q.flag;
    assign irq      = q.flag & int_en;
    assign rst_req  = q.rst;
endmodule

// File: rtl/wdt_window_ctr.sv
module wdt_window_ctr
    import wdt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_DIV   = 256,
    parameter int KEY_GAP   = 16,
    parameter int RST_DELAY = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [1:0]       cfg_src_sel,
    input  logic             cfg_prescale,
    input  logic             cfg_windowed,
    input  logic             cfg_int_en,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic             tick_lpo,
    input  logic             tick_irc,
    input  logic             tick_ext,
    input  logic             cnt_wr_valid,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             flag_clr,
    output logic             irq,
    output logic             irq_flag,
    output logic             rst_req,
    output logic [CNT_W-1:0] count
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             fired;
    } core_state_t;

    core_state_t q, d;
    logic tick;
    logic refresh;
    logic seq_err;
    logic win_fault;
    logic refresh_ok;
    logic fire;
    logic idle;

    assign idle = ~cfg_en;

    wdt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle | refresh_ok),
        .src_sel  (cfg_src_sel),
        .prescale (cfg_prescale),
        .tick_lpo (tick_lpo),
        .tick_irc (tick_irc),
        .tick_ext (tick_ext),
        .tick     (tick)
    );

    wdt_key_seq #(.DATA_W(CNT_W), .KEY_GAP(KEY_GAP)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .wr_valid (cnt_wr_valid),
        .wr_data  (cnt_wr_data),
        .refresh  (refresh),
        .seq_err  (seq_err)
    );

    wdt_alarm #(.RST_DELAY(RST_DELAY)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .fire     (fire),
        .fault    (seq_err | win_fault),
        .int_en   (cfg_int_en),
        .flag_clr (flag_clr),
        .irq      (irq),
        .irq_flag (irq_flag),
        .rst_req  (rst_req)
    );

    always_comb begin
        win_fault  = refresh & cfg_windowed & (q.count <= cfg_window);
        refresh_ok = refresh & ~win_fault;
        fire       = cfg_en & ~q.fired & (q.count >= cfg_timeout);

        d = q;
        if (idle) begin
            d.count = '0;
            d.fired = 1'b0;
        end else begin
            if (fire) d.fired = 1'b1;
            if (refresh_ok) begin
                d.count = '0;
            end else if (tick && q.count != '1) begin
                d.count = q.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.count;
endmodule

// File: rtl/wdt_window_ctr_chk.sv
module wdt_window_ctr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_en,
    input logic        cfg_int_en,
    input logic        irq,
    input logic        irq_flag,
    input logic        rst_req,
    input logic [15:0] count
);
    timeunit 1ns;
    timeprecision 1ps;

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (count == 16'd0 && !rst_req && !irq_flag && !irq));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_flag);

    p_rst_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && cfg_en) |=> rst_req);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && count != 16'hFFFF) |=>
            (count == $past(count) + 16'd1 || count == $past(count) || count == 16'd0));

    p_flag_needs_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(cfg_int_en));
endmodule

bind wdt_window_ctr wdt_window_ctr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_int_en (cfg_int_en),
    .irq        (irq),
    .irq_flag   (irq_flag),
    .rst_req    (rst_req),
    .count      (count)
);

// File: tb/wdt_window_ctr_test.sv
module wdt_window_ctr_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [15:0] K1 = 16'h02A6;
    localparam logic [15:0] K2 = 16'h80B4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_src_sel = 2'd0;
    logic        cfg_prescale = 1'b0;
    logic        cfg_windowed = 1'b0;
    logic        cfg_int_en = 1'b0;
    logic [15:0] cfg_timeout = 16'd0;
    logic [15:0] cfg_window = 16'd0;
    logic        tick_lpo = 1'b0;
    logic        tick_irc = 1'b0;
    logic        tick_ext = 1'b0;
    logic        cnt_wr_valid = 1'b0;
    logic [15:0] cnt_wr_data = 16'd0;
    logic        flag_clr = 1'b0;
    logic        irq, irq_flag, rst_req;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_window_ctr uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_sel(cfg_src_sel),
        .cfg_prescale(cfg_prescale), .cfg_windowed(cfg_windowed),
        .cfg_int_en(cfg_int_en), .cfg_timeout(cfg_timeout), .cfg_window(cfg_window),
        .tick_lpo(tick_lpo), .tick_irc(tick_irc), .tick_ext(tick_ext),
        .cnt_wr_valid(cnt_wr_valid), .cnt_wr_data(cnt_wr_data), .flag_clr(flag_clr),
        .irq(irq), .irq_flag(irq_flag), .rst_req(rst_req), .count(count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] sel, input logic pre, input logic win,
                           input logic ien, input logic [15:0] tmo, input logic [15:0] wnd);
        cfg_en = 1'b0;
        cyc(1);
        cfg_src_sel = sel; cfg_prescale = pre; cfg_windowed = win;
        cfg_int_en = ien; cfg_timeout = tmo; cfg_window = wnd;
        cfg_en = 1'b1;
    endtask

    task automatic wr(input logic [15:0] val);
        cnt_wr_valid = 1'b1;
        cnt_wr_data  = val;
        cyc(1);
        cnt_wr_valid = 1'b0;
    endtask

    // Expected outcome of a key whose second word sees count value c
    function automatic bit win_fault_exp(input bit windowed, input int c, input int w);
        return windowed && (c <= w);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        // R9: reset state
        chk("R9", "reset count", count, 0);
        chk("R9", "reset rst_req", rst_req, 0);
        chk("R9", "reset irq", irq, 0);
        rst_n = 1'b1;
        cyc(1);

        // R9: disabled with ticks and key writes
        tick_lpo = 1'b1; tick_irc = 1'b1; tick_ext = 1'b1;
        cyc(20);
        wr(K1); wr(16'h1234);
        chk("R9", "disabled count", count, 0);
        chk("R9", "disabled rst_req", rst_req, 0);
        chk("R9", "disabled irq_flag", irq_flag, 0);
        tick_lpo = 1'b0; tick_irc = 1'b0; tick_ext = 1'b0;

        // R1 / R10: bus clock timeout without interrupt
        restart(2'd0, 1'b0, 1'b0, 1'b0, 16'd20, 16'd0);
        cyc(20);
        chk("R1", "count at timeout", count, 20);
        chk("R1", "no early reset", rst_req, 0);
        cyc(1);
        chk("R1", "reset after timeout", rst_req, 1);
        wr(K1); wr(K2);
        cyc(5);
        chk("R10", "reset held", rst_req, 1);

        // R3 / R2: prescaled low-power source
        restart(2'd1, 1'b1, 1'b0, 1'b0, 16'd1000, 16'd0);
        tick_lpo = 1'b1;
        cyc(767);
        chk("R3", "count after 767 ticks", count, 2);
        cyc(1);
        chk("R3", "count after 768 ticks", count, 3);
        tick_lpo = 1'b0;

        // R2: unselected sources ignored, selected counted
        restart(2'd2, 1'b0, 1'b0, 1'b0, 16'd1000, 16'd0);
        tick_lpo = 1'b1; tick_ext = 1'b1;
        cyc(10);
        chk("R2", "irc selected, others ignored", count, 0);
        tick_lpo = 1'b0; tick_ext = 1'b0; tick_irc = 1'b1;
        cyc(5);
        tick_irc = 1'b0;
        chk("R2", "irc ticks counted", count, 5);
        restart(2'd3, 1'b0, 1'b0, 1'b0, 16'd1000, 16'd0);
        tick_irc = 1'b1;
        cyc(4);
        tick_irc = 1'b0; tick_ext = 1'b1;
        cyc(7);
        tick_ext = 1'b0;
        chk("R2", "ext ticks only", count, 7);

        // R4: refresh and ignored writes
        restart(2'd0, 1'b0, 1'b0, 1'b0, 16'd100, 16'd0);
        cyc(10);
        wr(K1);
        chk("R4", "count after first key", count, 11);
        wr(K2);
        chk("R4", "count cleared", count, 0);
        wr(16'h1111);
        chk("R4", "stray write ignored", count, 1);
        chk("R4", "stray write no reset", rst_req, 0);
        wr(K1);
        cyc(15);
        wr(K2);
        chk("R4", "second key on 16th clock clears", count, 0);
        chk("R4", "second key on 16th clock no reset", rst_req, 0);

        // R5: wrong second word, late second word
        restart(2'd0, 1'b0, 1'b0, 1'b0, 16'd100, 16'd0);
        cyc(5);
        wr(K1);
        chk("R5", "pending key no reset", rst_req, 0);
        wr(16'h80B5);
        chk("R5", "wrong second word reset", rst_req, 1);
        restart(2'd0, 1'b0, 1'b0, 1'b0, 16'd100, 16'd0);
        wr(K1);
        cyc(15);
        chk("R5", "15 idle clocks no reset", rst_req, 0);
        cyc(1);
        chk("R5", "16 idle clocks reset", rst_req, 1);

        // R6: window boundary
        restart(2'd0, 1'b0, 1'b1, 1'b0, 16'd100, 16'd30);
        cyc(29);
        wr(K1); wr(K2);
        chk("R6", "refresh at window value", rst_req, 1);
        restart(2'd0, 1'b0, 1'b1, 1'b0, 16'd100, 16'd30);
        cyc(30);
        wr(K1); wr(K2);
        chk("R6", "refresh above window no reset", rst_req, 0);
        chk("R6", "refresh above window clears", count, 0);

        // R7: interrupt then delayed reset
        restart(2'd0, 1'b0, 1'b0, 1'b1, 16'd10, 16'd0);
        cyc(10);
        chk("R7", "flag before timeout", irq_flag, 0);
        cyc(1);
        chk("R7", "flag set", irq_flag, 1);
        chk("R7", "irq set", irq, 1);
        chk("R7", "no reset with flag", rst_req, 0);
        cyc(127);
        chk("R7", "no reset at 127", rst_req, 0);
        cyc(1);
        chk("R7", "reset at 128", rst_req, 1);

        // R8: flag clear keeps pending reset
        restart(2'd0, 1'b0, 1'b0, 1'b1, 16'd10, 16'd0);
        cyc(11);
        flag_clr = 1'b1;
        cyc(1);
        flag_clr = 1'b0;
        chk("R8", "flag cleared", irq_flag, 0);
        chk("R8", "irq cleared", irq, 0);
        cyc(126);
        chk("R8", "reset still pending", rst_req, 0);
        cyc(1);
        chk("R8", "reset not cancelled", rst_req, 1);

        // Random refresh points, timeouts and windows (R1, R4, R6)
        for (int i = 0; i < 24; i++) begin
            int t, p, w;
            bit win, exp_f;
            t = 8 + int'($urandom % 50);
            p = 1 + int'($urandom % (t - 4));
            w = int'($urandom % t);
            win = $urandom % 2;
            restart(2'd0, 1'b0, win, 1'b0, 16'(t), 16'(w));
            cyc(p);
            wr(K1); wr(K2);
            exp_f = win_fault_exp(win, p + 1, w);
            chk("R6", "random window outcome", rst_req, int'(exp_f));
            if (!exp_f) begin
                chk("R4", "random refresh clears", count, 0);
                cyc(t);
                chk("R1", "random no early reset", rst_req, 0);
                cyc(1);
                chk("R1", "random timeout reset", rst_req, 1);
            end
        end

        cfg_en = 1'b0;
        cyc(2);
        chk("R9", "disable drops reset", rst_req, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule